// File: doc/BRIEF.md
# NOR Flash Sector Erase Sequencer

This block erases a contiguous range of sectors in a 16-bit parallel NOR flash that uses the unlock-cycle command set. A start strobe carries a first and a last sector index. The same request also carries a protect bitmap with one bit per sector and a table holding the word base address of each sector. The block first counts how many sectors in the range are protected. It then visits the unprotected sectors in ascending order. For each one it sends the unlock and erase command writes, waits a minimum settling time, and polls the sector for completion. It then writes the read-mode command so the array can be read again.

The bank base is the base address of sector 0. All unlock addresses are offsets from that base. Timeouts abort the remaining range. An ill-formed request is refused without touching the bus. The delay and the timeout are clock-cycle counts set by parameters. The protect bitmap and the address table must stay stable while the block is busy. The first and last indices are captured when a request is accepted.

Top module: `nor_erase_seq`

## Requirements
- R1: A request with a negative first index, with first greater than last, or with last at or above the sector count is refused. done_o pulses in the cycle after the strobe, fail_o is 1, prot_cnt_o is 0, and no bus write or read is made.
- R2: For an accepted request, prot_cnt_o holds the number of sectors with index in [first, last] whose protect bit is 1. It is valid from the cycle after the strobe until the next accepted request.
- R3: Sectors in the range are handled in ascending index order. A protected sector receives no bus access at all.
- R4: Each unprotected sector gets six writes in this order. Data 0x00AA goes to bank+0x555, then 0x0055 to bank+0x2AA, 0x0080 to bank+0x555, 0x00AA to bank+0x555, 0x0055 to bank+0x2AA, and finally 0x0030 to the sector base.
- R5: The first status read of a sector comes no sooner than DELAY_CYC cycles after its 0x0030 write.
- R6: Status reads go to the sector base. Read data is sampled in the cycle after the read strobe. The sector counts as complete only when bits 7 and 15 are both 1.
- R7: After each sector ends, whether it completed or timed out, exactly one write of 0x00F0 to the bank base follows.
- R8: If a sector does not complete within TOUT_CYC cycles of polling, the block writes 0x00F0 to the bank base and sets fail_o. It touches no further sector, and fail_o stays 1 until the next accepted request.
- R9: Every access is a one-cycle strobe, and the write and read strobes are never high together.
- R10: A start strobe while busy_o is high has no effect on the range, the count or the bus sequence.
- R11: After reset all outputs are 0. done_o is high for exactly one cycle per accepted or refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| first_i | input | IDX_W | First sector index, signed |
| last_i | input | IDX_W | Last sector index, signed |
| protect_i | input | N_SECT | Per-sector protect bits |
| base_tbl_i | input | N_SECT*ADDR_W | Sector word base addresses, sector i at bits [i*ADDR_W +: ADDR_W] |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | 16 | Read data, valid the cycle after bus_re_o |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| fail_o | output | 1 | Refused or timed-out request |
| prot_cnt_o | output | CNT_W | Protected sectors counted in the range |

## Verification
The range walk is driven with several protect and range patterns. These are a whole-bank range with nothing protected, a range with protected sectors at both of its ends, a single sector, a range with a protected sector just outside it, and a range where every sector is protected. Together they separate correct range bounds from off-by-one errors, and skipping from erasing. The flash model answers with one half-ready word (0x0080) before full completion. This tells a check of both byte lanes from a check of one. Directed runs cover the three kinds of refused request, a sector that never completes, a second strobe during a run, and the gap between the sector command and the first poll.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_CMD, ST_DELAY, ST_PRD, ST_PCHK, ST_RST, ST_FIN
  } seq_st_e;

  localparam logic [15:0] CMD_UNLK1 = 16'h00AA;
  localparam logic [15:0] CMD_UNLK2 = 16'h0055;
  localparam logic [15:0] CMD_ERSET = 16'h0080;
  localparam logic [15:0] CMD_SECT  = 16'h0030;
  localparam logic [15:0] CMD_READ  = 16'h00F0;
  localparam logic [15:0] POLL_MASK = 16'h8080;
  localparam int          OFS_A     = 'h555;
  localparam int          OFS_B     = 'h2AA;
  localparam int          LAST_STEP = 5;
endpackage

// File: rtl/nor_cmd_step.sv
module nor_cmd_step import nor_erase_pkg::*; #(
  parameter int ADDR_W = 20
) (
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] bank_base_i,
  input  logic [ADDR_W-1:0] sect_base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o
);
  localparam logic [ADDR_W-1:0] OA = ADDR_W'(OFS_A);
  localparam logic [ADDR_W-1:0] OB = ADDR_W'(OFS_B);

  always_comb begin
    unique case (step_i)
      3'd0:    begin addr_o = bank_base_i + OA; data_o = CMD_UNLK1; end
      3'd1:    begin addr_o = bank_base_i + OB; data_o = CMD_UNLK2; end
      3'd2:    begin addr_o = bank_base_i + OA; data_o = CMD_ERSET; end
      3'd3:    begin addr_o = bank_base_i + OA; data_o = CMD_UNLK1; end
      3'd4:    begin addr_o = bank_base_i + OB; data_o = CMD_UNLK2; end
      default: begin addr_o = sect_base_i;      data_o = CMD_SECT;  end
    endcase
  end
endmodule

// File: rtl/nor_prot_count.sv
module nor_prot_count #(
  parameter int N_SECT = 8,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 4
) (
  input  logic signed [IDX_W-1:0] first_i,
  input  logic signed [IDX_W-1:0] last_i,
  input  logic [N_SECT-1:0]       protect_i,
  output logic [CNT_W-1:0]        count_o
);
  logic [N_SECT-1:0] hit;

  for (genvar i = 0; i < N_SECT; i++) begin : g_hit
    assign hit[i] = protect_i[i] && (int'(first_i) <= i) && (i <= int'(last_i));
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < N_SECT; i++) count_o = count_o + CNT_W'(hit[i]);
  end
endmodule

// File: rtl/nor_cycle_timer.sv
module nor_cycle_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq import nor_erase_pkg::*; #(
  parameter int N_SECT    = 8,
  parameter int ADDR_W    = 20,
  parameter int DELAY_CYC = 100000,
  parameter int TOUT_CYC  = 2000000,
  localparam int IDX_W    = $clog2(N_SECT) + 2,
  localparam int CNT_W    = $clog2(N_SECT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [IDX_W-1:0]  first_i,
  input  logic signed [IDX_W-1:0]  last_i,
  input  logic [N_SECT-1:0]        protect_i,
  input  logic [N_SECT*ADDR_W-1:0] base_tbl_i,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [15:0]              bus_wdata_o,
  output logic                     bus_we_o,
  output logic                     bus_re_o,
  input  logic [15:0]              bus_rdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         prot_cnt_o
);
  localparam int SW   = $clog2(N_SECT);
  localparam int TMAX = (DELAY_CYC > TOUT_CYC) ? DELAY_CYC : TOUT_CYC;
  localparam int TW   = $clog2(TMAX + 2);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  cur_q, last_q;
  logic [2:0]        step_q;
  logic              abort_q, fail_q;
  logic [CNT_W-1:0]  pcnt_q, pcnt_w;
  logic [TW-1:0]     tcnt;
  logic              bad_req, past_last, poll_ok, tout_hit, delay_hit, tclr;
  logic [SW-1:0]     idx;
  logic [ADDR_W-1:0] bank_base, sect_base, step_addr;
  logic [15:0]       step_data;

  assign idx       = cur_q[SW-1:0];
  assign bank_base = base_tbl_i[ADDR_W-1:0];
  assign sect_base = base_tbl_i[idx*ADDR_W +: ADDR_W];
  assign bad_req   = first_i[IDX_W-1] || (first_i > last_i) || (int'(last_i) >= N_SECT);
  assign past_last = cur_q > last_q;
  assign poll_ok   = (bus_rdata_i & POLL_MASK) == POLL_MASK;
  assign tout_hit  = tcnt >= TW'(TOUT_CYC - 1);
  assign delay_hit = tcnt >= TW'(DELAY_CYC - 1);
  assign tclr      = (st_q == ST_CMD && step_q == 3'(LAST_STEP)) ||
                     (st_q == ST_DELAY && delay_hit);

  nor_prot_count #(.N_SECT(N_SECT), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_cnt (
    .first_i(first_i), .last_i(last_i), .protect_i(protect_i), .count_o(pcnt_w)
  );

  nor_cmd_step #(.ADDR_W(ADDR_W)) i_step (
    .step_i(step_q), .bank_base_i(bank_base), .sect_base_i(sect_base),
    .addr_o(step_addr), .data_o(step_data)
  );

  nor_cycle_timer #(.TW(TW)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tclr), .cnt_o(tcnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      step_q  <= '0;
      abort_q <= 1'b0;
      fail_q  <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          abort_q <= 1'b0;
          if (bad_req) begin
            fail_q <= 1'b1;
            pcnt_q <= '0;
            st_q   <= ST_FIN;
          end else begin
            fail_q <= 1'b0;
            pcnt_q <= pcnt_w;
            cur_q  <= first_i;
            last_q <= last_i;
            st_q   <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (past_last)           st_q  <= ST_FIN;
          else if (protect_i[idx]) cur_q <= cur_q + 1'b1;
          else begin
            step_q <= '0;
            st_q   <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (step_q == 3'(LAST_STEP)) st_q   <= ST_DELAY;
          else                         step_q <= step_q + 1'b1;
        end
        ST_DELAY: if (delay_hit) st_q <= ST_PRD;
        ST_PRD:   st_q <= ST_PCHK;
        ST_PCHK: begin
          if (poll_ok) st_q <= ST_RST;
          else if (tout_hit) begin
            abort_q <= 1'b1;
            fail_q  <= 1'b1;
            st_q    <= ST_RST;
          end else st_q <= ST_PRD;
        end
        ST_RST: begin
          if (abort_q) st_q <= ST_FIN;
          else begin
            cur_q <= cur_q + 1'b1;
            st_q  <= ST_SEL;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    unique case (st_q)
      ST_CMD: begin bus_we_o = 1'b1; bus_addr_o = step_addr; bus_wdata_o = step_data; end
      ST_PRD: begin bus_re_o = 1'b1; bus_addr_o = sect_base; end
      ST_RST: begin bus_we_o = 1'b1; bus_addr_o = bank_base; bus_wdata_o = CMD_READ; end
      default: ;
    endcase
  end

  assign busy_o     = st_q != ST_IDLE;
  assign done_o     = st_q == ST_FIN;
  assign fail_o     = fail_q;
  assign prot_cnt_o = pcnt_q;

  p_reject_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && bad_req) |=> (done_o && fail_o && !bus_we_o && !bus_re_o));
  p_cmd_then_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == CMD_SECT) |=> (!bus_re_o && !bus_we_o));
  p_timeout_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PCHK && tout_hit && !poll_ok) |=>
      (bus_we_o && bus_wdata_o == CMD_READ && bus_addr_o == bank_base && fail_o));
  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |=> !bus_re_o);
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(prot_cnt_o));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/test_nor_erase_seq.sv
module test_nor_erase_seq;
  localparam int NS = 8, AW = 20, DLY = 16, TOUT = 60, IW = 5, CW = 4;
  localparam logic [AW-1:0] BANK = 20'h40000;

  typedef struct packed {
    int first; int last; logic [7:0] prot; int cnt; logic [7:0] mask;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{0, 7, 8'h00, 0, 8'hFF},
    '{2, 5, 8'h24, 2, 8'h18},
    '{3, 3, 8'h00, 0, 8'h08},
    '{1, 6, 8'h83, 1, 8'h7C},
    '{4, 7, 8'hF0, 4, 8'h00}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic signed [IW-1:0] first = 0, last = 0;
  logic [NS-1:0] prot = 0;
  logic [NS*AW-1:0] tbl;
  logic [AW-1:0] addr;
  logic [15:0] wdata, rdata;
  logic we, re, busy, done, fail;
  logic [CW-1:0] pcnt;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nor_erase_seq #(.N_SECT(NS), .ADDR_W(AW), .DELAY_CYC(DLY), .TOUT_CYC(TOUT)) i_nor_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .first_i(first), .last_i(last),
    .protect_i(prot), .base_tbl_i(tbl), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_we_o(we), .bus_re_o(re), .bus_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .prot_cnt_o(pcnt)
  );

  // flash model and bus monitor
  logic [AW-1:0] log_a [0:127];
  logic [15:0]   log_d [0:127];
  int wn, rn, done_n, both_n, min_gap, cyc, cmd_cyc, rd_since;
  int need [NS];
  int left [NS];
  logic [NS-1:0] erased;
  bit clr_log = 0;

  function automatic int sect_of(logic [AW-1:0] a);
    for (int k = 0; k < NS; k++) if (a == tbl[k*AW +: AW]) return k;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_log) begin
      wn <= 0; rn <= 0; done_n <= 0; both_n <= 0; min_gap <= 1000000; erased <= '0;
    end else begin
      if (done) done_n <= done_n + 1;
      if (we && re) both_n <= both_n + 1;
      if (we) begin
        if (wn < 128) begin log_a[wn] <= addr; log_d[wn] <= wdata; end
        wn <= wn + 1;
        if (wdata == 16'h0030 && sect_of(addr) >= 0) begin
          erased[sect_of(addr)] <= 1'b1;
          left[sect_of(addr)] <= need[sect_of(addr)];
          cmd_cyc <= cyc;
          rd_since <= 0;
        end
      end
      if (re) begin
        rn <= rn + 1;
        rd_since <= rd_since + 1;
        if (rd_since == 0 && (cyc - cmd_cyc) < min_gap) min_gap <= cyc - cmd_cyc;
        if (sect_of(addr) >= 0) begin
          if (left[sect_of(addr)] == 0)      rdata <= 16'h8080;
          else if (left[sect_of(addr)] == 1) rdata <= 16'h0080;
          else                               rdata <= 16'h0000;
          if (left[sect_of(addr)] > 0) left[sect_of(addr)] <= left[sect_of(addr)] - 1;
        end else rdata <= 16'h0000;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk); clr_log = 1;
    @(negedge clk); clr_log = 0;
  endtask

  task automatic launch(int f, int l, logic [7:0] p);
    @(negedge clk);
    first = IW'(f); last = IW'(l); prot = p; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_n == 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic bit seq_ok(logic [7:0] mask);
    int j = 0;
    logic [AW-1:0] ea [7];
    logic [15:0] ed [7] = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0030, 16'h00F0};
    for (int k = 0; k < NS; k++) if (mask[k]) begin
      ea = '{BANK + 20'h555, BANK + 20'h2AA, BANK + 20'h555, BANK + 20'h555,
             BANK + 20'h2AA, tbl[k*AW +: AW], BANK};
      for (int s = 0; s < 7; s++) begin
        if (log_a[j] != ea[s] || log_d[j] != ed[s]) return 0;
        j++;
      end
    end
    return 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc = 0; cmd_cyc = 0; rd_since = 0; rdata = 0;
    for (int k = 0; k < NS; k++) begin
      tbl[k*AW +: AW] = BANK + AW'(k * 'h1000);
      need[k] = 2; left[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fail && pcnt == 0 && !we && !re, "R11 reset", {busy, done, fail, we, re}, 0);
    rst_n = 1;
    clear();

    foreach (VECS[v]) begin
      int nse;
      clear();
      launch(VECS[v].first, VECS[v].last, VECS[v].prot);
      wait_done();
      nse = $countones(VECS[v].mask);
      chk(pcnt == CW'(VECS[v].cnt), "R2 prot count", pcnt, VECS[v].cnt);
      chk(erased == VECS[v].mask, "R3 erased set", erased, VECS[v].mask);
      chk(wn == 7 * nse, "R7 write count", wn, 7 * nse);
      chk(seq_ok(VECS[v].mask), "R4 command order", 0, 1);
      chk(rn == 3 * nse, "R6 poll count", rn, 3 * nse);
      if (nse > 0) chk(min_gap >= DLY, "R5 delay before poll", min_gap, DLY);
      chk(!fail, "R8 no fail", fail, 0);
      chk(done_n == 1 && both_n == 0, "R11 R9 done pulse", done_n, 1);
    end

    // R1 refused requests
    clear(); launch(-1, 3, 8'h00);
    chk(done && fail && pcnt == 0, "R1 negative first", {done, fail}, 3);
    wait_done(); chk(wn == 0 && rn == 0, "R1 no access", wn + rn, 0);
    clear(); launch(5, 2, 8'h00);
    chk(done && fail, "R1 first>last", {done, fail}, 3);
    wait_done(); chk(wn == 0 && done_n == 1, "R1 no writes", wn, 0);
    clear(); launch(0, 8, 8'h00);
    chk(done && fail, "R1 last out of range", {done, fail}, 3);
    wait_done();

    // R8 timeout abort on stuck sector 1
    need[1] = 1000;
    clear(); launch(0, 3, 8'h00);
    wait_done();
    chk(fail, "R8 fail set", fail, 1);
    chk(erased == 8'h03, "R8 stops range", erased, 8'h03);
    chk(wn == 14 && log_a[13] == BANK && log_d[13] == 16'h00F0, "R8 reset write", wn, 14);
    need[1] = 2;

    // R10 start while busy ignored
    clear(); launch(0, 1, 8'h20);
    repeat (4) @(negedge clk);
    first = 5; last = 5; start = 1;
    @(negedge clk); start = 0;
    wait_done();
    chk(erased == 8'h03 && pcnt == 0, "R10 busy start ignored", erased, 8'h03);
    chk(done_n == 1 && !fail, "R10 single done", done_n, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule